// File: doc/BRIEF.md
# Load Displacement Extension Parser

This block sits between instruction fetch and the load unit of a processor pipeline. After the opcode halfword of an absolute or register-relative load has been fetched, a start request hands the block the current fetch pointer. The block then takes the extension halfwords that follow, one per valid/ready handshake, and advances the fetch pointer by two bytes for each halfword it takes.

The first extension halfword carries four things: a form flag, a sign flag, a two-bit load sub-type and twelve displacement bits. The form flag decides whether a second halfword is needed. The short form yields a 12-bit displacement, and the sign flag fills every bit above it with ones. The long form places those twelve bits above a full second halfword, and the sign flag fills only the top nibble. When parsing ends, the block presents the 32-bit displacement, the sub-type and the total instruction length in halfwords with a one-cycle done pulse. These outputs hold their values until the next decode completes.

Top module: `ext_disp_decoder`

## Requirements
- R1: After a synchronous reset, `done_o`, `hw_ready_o` and `busy_o` are low, and `disp_o`, `subtype_o`, `len_o` and `fetch_ptr_o` are all zero.
- R2: A `start_i` sampled while idle loads `fetch_ptr_o` from `fetch_ptr_i`, and in the next cycle `busy_o` and `hw_ready_o` are high.
- R3: When bit 15 of the first extension halfword is 0 (short form), only that halfword is consumed, and `len_o` reports 2.
- R4: When bit 15 of the first extension halfword is 1 (long form), one more halfword is consumed, and `len_o` reports 3.
- R5: `subtype_o` equals bits 13:12 of the first extension halfword in both forms.
- R6: Short form: `disp_o[11:0]` equals bits 11:0 of the first halfword, and `disp_o[31:12]` are all ones when bit 14 is 1 and all zeros otherwise.
- R7: Long form: `disp_o[15:0]` is the second halfword and `disp_o[27:16]` is bits 11:0 of the first. `disp_o[31:28]` are all ones when bit 14 of the first halfword is 1 and all zeros otherwise.
- R8: Every accepted halfword (`hw_valid_i` and `hw_ready_o` both high at a clock edge) advances `fetch_ptr_o` by 2. A cycle with `hw_valid_i` low consumes nothing and leaves the pointer unchanged.
- R9: `done_o` is high for exactly one cycle, the cycle after the final halfword is accepted. `disp_o`, `subtype_o` and `len_o` do not change between completions.
- R10: A `start_i` that arrives while a decode is in progress is ignored: the pointer is not reloaded and the decode continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin parsing a new extension |
| fetch_ptr_i | input | ADDR_W | Fetch pointer loaded on an accepted start |
| hw_valid_i | input | 1 | Extension halfword available |
| hw_data_i | input | 16 | Extension halfword |
| hw_ready_o | output | 1 | Block will take a halfword this cycle |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle completion pulse |
| disp_o | output | 32 | Decoded signed displacement |
| subtype_o | output | 2 | Load sub-type |
| len_o | output | 2 | Instruction length in halfwords (2 or 3) |
| fetch_ptr_o | output | ADDR_W | Fetch pointer, advanced per halfword |

## Verification
The bench has to detect a wrong state even though the state is not a port, so it watches the signals that depend on it. If the first halfword is misrouted to the wait-second state, `done_o` stays low one cycle too long and the pointer ends 2 bytes too far. A missed long-form transition gives a length of 2 and a displacement with the wrong fill, visible in the done cycle itself. If a busy block accepts a stray start, `fetch_ptr_o` is reloaded, which shows in the very next cycle. If the state fails to return to idle, a new start is refused and `hw_ready_o` misbehaves within a cycle.

// File: rtl/ext_disp_pkg.sv
package ext_disp_pkg;
   localparam int HW_W     = 16;
   localparam int DISP_W   = 32;
   localparam int LEN_W    = 2;
   localparam int SUB_W    = 2;
   localparam int LOW_BITS = 12;

   localparam int FORM_BIT = 15;
   localparam int SIGN_BIT = 14;
   localparam int SUB_LSB  = 12;

   localparam logic [LEN_W-1:0] LEN_SHORT = 2'd2;
   localparam logic [LEN_W-1:0] LEN_LONG  = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT1 = 2'd1,
      ST_WAIT2 = 2'd2
   } dec_state_e;

   typedef struct packed {
      logic                is_long;
      logic                neg;
      logic [SUB_W-1:0]    sub;
      logic [LOW_BITS-1:0] low;
   } ext_fields_t;
endpackage

// File: rtl/ext_disp_fields.sv
module ext_disp_fields
   import ext_disp_pkg::*;
(
   input  logic [HW_W-1:0] hw_i,
   output ext_fields_t     fields_o
);
   always_comb begin
      fields_o.is_long = hw_i[FORM_BIT];
      fields_o.neg     = hw_i[SIGN_BIT];
      fields_o.sub     = hw_i[SUB_LSB +: SUB_W];
      fields_o.low     = hw_i[LOW_BITS-1:0];
   end
endmodule

// File: rtl/ext_disp_assemble.sv
module ext_disp_assemble
   import ext_disp_pkg::*;
#(
   parameter int OUT_W   = DISP_W,
   parameter int LONG_HI = 28
) (
   input  ext_fields_t      fields_i,
   input  logic [HW_W-1:0]  second_i,
   output logic [OUT_W-1:0] disp_o
);
   localparam int LONG_LO = HW_W;

   if (OUT_W < LONG_HI) begin : g_bad_width
      $error("ext_disp_assemble: OUT_W too small for long form");
   end
   if (LONG_HI - LONG_LO != LOW_BITS) begin : g_bad_split
      $error("ext_disp_assemble: long-form field split inconsistent");
   end

   logic [OUT_W-1:0] short_v;
   logic [OUT_W-1:0] long_v;

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      if (b < LOW_BITS) begin : g_s_low
         assign short_v[b] = fields_i.low[b];
      end else begin : g_s_fill
         assign short_v[b] = fields_i.neg;
      end

      if (b < LONG_LO) begin : g_l_sec
         assign long_v[b] = second_i[b];
      end else if (b < LONG_HI) begin : g_l_mid
         assign long_v[b] = fields_i.low[b-LONG_LO];
      end else begin : g_l_fill
         assign long_v[b] = fields_i.neg;
      end
   end

   assign disp_o = fields_i.is_long ? long_v : short_v;
endmodule

// File: rtl/ext_disp_fetch_ptr.sv
module ext_disp_fetch_ptr #(
   parameter int ADDR_W     = 32,
   parameter int STEP_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

   if (STEP_BYTES < 1) begin : g_bad_step
      $error("ext_disp_fetch_ptr: STEP_BYTES must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)         ptr_o <= '0;
      else if (load_i) ptr_o <= base_i;
      else if (adv_i)  ptr_o <= ptr_o + STEP_V;
   end
endmodule

// File: rtl/ext_disp_decoder.sv
module ext_disp_decoder
   import ext_disp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   fetch_ptr_i,
   input  logic                hw_valid_i,
   input  logic [HW_W-1:0]     hw_data_i,
   output logic                hw_ready_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [DISP_W-1:0]   disp_o,
   output logic [SUB_W-1:0]    subtype_o,
   output logic [LEN_W-1:0]    len_o,
   output logic [ADDR_W-1:0]   fetch_ptr_o
);
   localparam int STEP_BYTES = HW_W / 8;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ext_disp_decoder: ADDR_W must be at least 4");
   end

   dec_state_e        state_q;
   logic [HW_W-1:0]   first_q;
   logic [HW_W-1:0]   first_sel;
   ext_fields_t       fields;
   logic [DISP_W-1:0] disp_next;
   logic              accept;
   logic              start_go;
   logic              finish;

   assign hw_ready_o = (state_q != ST_IDLE);
   assign busy_o     = hw_ready_o;
   assign accept     = hw_valid_i && hw_ready_o;
   assign start_go   = start_i && (state_q == ST_IDLE);
   assign first_sel  = (state_q == ST_WAIT2) ? first_q : hw_data_i;
   assign finish     = accept && ((state_q == ST_WAIT2) ||
                                  (state_q == ST_WAIT1 && !fields.is_long));

   ext_disp_fields u_fields (
      .hw_i     (first_sel),
      .fields_o (fields)
   );

   ext_disp_assemble #(.OUT_W(DISP_W)) u_asm (
      .fields_i (fields),
      .second_i (hw_data_i),
      .disp_o   (disp_next)
   );

   ext_disp_fetch_ptr #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .load_i (start_go),
      .base_i (fetch_ptr_i),
      .adv_i  (accept),
      .ptr_o  (fetch_ptr_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         first_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:  if (start_go) state_q <= ST_WAIT1;
            ST_WAIT1: if (accept) begin
                         first_q <= hw_data_i;
                         state_q <= fields.is_long ? ST_WAIT2 : ST_IDLE;
                      end
            ST_WAIT2: if (accept) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         done_o    <= 1'b0;
         disp_o    <= '0;
         subtype_o <= '0;
         len_o     <= '0;
      end else begin
         done_o <= finish;
         if (finish) begin
            disp_o    <= disp_next;
            subtype_o <= fields.sub;
            len_o     <= fields.is_long ? LEN_LONG : LEN_SHORT;
         end
      end
   end
endmodule

// File: rtl/ext_disp_decoder_chk.sv
module ext_disp_decoder_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              start_i,
   input logic              hw_valid_i,
   input logic              hw_ready_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [31:0]       disp_o,
   input logic [1:0]        len_o,
   input logic [ADDR_W-1:0] fetch_ptr_o
);
   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R3
   len_legal_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (len_o == 2'd2 || len_o == 2'd3));

   // R6
   short_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && len_o == 2'd2) |-> (disp_o[31:12] == '0 || disp_o[31:12] == '1));

   // R7
   long_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && len_o == 2'd3) |-> (disp_o[31:28] == 4'h0 || disp_o[31:28] == 4'hF));

   // R8
   ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (hw_valid_i && hw_ready_o) |=> (fetch_ptr_o == $past(fetch_ptr_o) + TWO));

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i && !hw_valid_i) |=> $stable(fetch_ptr_o));

   // R2
   start_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> hw_ready_o);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(hw_valid_i && hw_ready_o) |=> ($stable(disp_o) && $stable(len_o)));
endmodule

bind ext_disp_decoder ext_disp_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .start_i     (start_i),
   .hw_valid_i  (hw_valid_i),
   .hw_ready_o  (hw_ready_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .disp_o      (disp_o),
   .len_o       (len_o),
   .fetch_ptr_o (fetch_ptr_o)
);

// File: tb/tb_ext_disp_decoder.sv
module tb_ext_disp_decoder;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst;
   logic          start_i;
   logic [AW-1:0] fetch_ptr_i;
   logic          hw_valid_i;
   logic [15:0]   hw_data_i;
   logic          hw_ready_o, busy_o, done_o;
   logic [31:0]   disp_o;
   logic [1:0]    subtype_o, len_o;
   logic [AW-1:0] fetch_ptr_o;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   ext_disp_decoder #(.ADDR_W(AW)) dut (
      .clk(clk), .rst(rst), .start_i(start_i), .fetch_ptr_i(fetch_ptr_i),
      .hw_valid_i(hw_valid_i), .hw_data_i(hw_data_i), .hw_ready_o(hw_ready_o),
      .busy_o(busy_o), .done_o(done_o), .disp_o(disp_o), .subtype_o(subtype_o),
      .len_o(len_o), .fetch_ptr_o(fetch_ptr_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_disp(input logic [15:0] f, input logic [15:0] s);
      if (f[15]) return {{4{f[14]}}, f[11:0], s};
      return {{20{f[14]}}, f[11:0]};
   endfunction

   task automatic tick;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1; start_i = 0; hw_valid_i = 0; hw_data_i = '0; fetch_ptr_i = '0;
      tick; tick;
      rst = 0;
      tick;
      chk("R1 done", {31'b0, done_o}, 0);
      chk("R1 ready", {31'b0, hw_ready_o}, 0);
      chk("R1 busy", {31'b0, busy_o}, 0);
      chk("R1 disp", disp_o, 0);
      chk("R1 len", {30'b0, len_o}, 0);
      chk("R1 ptr", fetch_ptr_o, 0);
   endtask

   task automatic t_decode(input logic [AW-1:0] base, input logic [15:0] f,
                           input logic [15:0] s, input int stall);
      logic [31:0] exp_d;
      exp_d = model_disp(f, s);
      start_i = 1; fetch_ptr_i = base;
      tick;
      start_i = 0; fetch_ptr_i = ~base;
      chk("R2 ready", {31'b0, hw_ready_o}, 1);
      chk("R2 ptr", fetch_ptr_o, base);
      for (int i = 0; i < stall; i++) begin
         tick;
         chk("R8 stall ptr", fetch_ptr_o, base);
         chk("R8 stall done", {31'b0, done_o}, 0);
      end
      hw_valid_i = 1; hw_data_i = f;
      tick;
      chk("R8 ptr first", fetch_ptr_o, base + 2);
      if (f[15]) begin
         chk("R4 no done yet", {31'b0, done_o}, 0);
         chk("R4 ready second", {31'b0, hw_ready_o}, 1);
         hw_data_i = s;
         tick;
         chk("R8 ptr second", fetch_ptr_o, base + 4);
         chk("R4 len", {30'b0, len_o}, 3);
         chk("R7 disp", disp_o, exp_d);
      end else begin
         chk("R3 len", {30'b0, len_o}, 2);
         chk("R6 disp", disp_o, exp_d);
      end
      hw_valid_i = 0; hw_data_i = 16'hFFFF;
      chk("R9 done", {31'b0, done_o}, 1);
      chk("R5 subtype", {30'b0, subtype_o}, {30'b0, f[13:12]});
      tick;
      chk("R9 done drop", {31'b0, done_o}, 0);
      chk("R3 idle", {31'b0, hw_ready_o}, 0);
      tick;
      chk("R9 hold disp", disp_o, exp_d);
      chk("R9 hold sub", {30'b0, subtype_o}, {30'b0, f[13:12]});
   endtask

   task automatic t_busy_start;
      start_i = 1; fetch_ptr_i = 32'h0000_1000;
      tick;
      fetch_ptr_i = 32'h0000_9000;
      tick;
      start_i = 0;
      chk("R10 ptr kept", fetch_ptr_o, 32'h0000_1000);
      chk("R10 still busy", {31'b0, busy_o}, 1);
      hw_valid_i = 1; hw_data_i = 16'h2055;
      tick;
      hw_valid_i = 0;
      chk("R10 finishes", {31'b0, done_o}, 1);
      chk("R10 disp", disp_o, 32'h0000_0055);
      chk("R10 ptr end", fetch_ptr_o, 32'h0000_1002);
      tick;
   endtask

   initial begin
      t_reset;
      t_decode(32'h0000_0100, 16'h1ABC, 16'h0000, 0);
      t_decode(32'h0000_0200, 16'h6F01, 16'h0000, 2);
      t_decode(32'h0000_0300, 16'hB123, 16'h4567, 0);
      t_decode(32'h0000_0400, 16'hC0FE, 16'h89AB, 1);
      t_decode(32'hFFFF_FFFC, 16'hF800, 16'h0001, 0);
      t_busy_start;
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule